// File: doc/BRIEF.md
# Multiplexed-Address DRAM Array Emulator

A clocked, synthesizable model of a single-bit-wide dynamic memory whose address reaches it in two halves over one shared bus. The storage holds 2^(2*AW) bits arranged as a square of rows and columns (256 x 256 with the default AW = 8). The host first presents a row number on `addr` and pulls the row strobe `ras_n` low. It then presents a column number on the same pins and pulls the column strobe `cas_n` low. The `we_n` level seen at that moment chooses between a write and a read.

Opening a row copies the whole row into a row register. Every column access works on that register and never on the array. While the row strobe stays low, any number of column cycles may follow (page mode). When the row strobe returns high, the register is copied back into the row that was opened.

All strobes are sampled on rising edges of `clk`. An edge is a change between two consecutive samples. The interface is paced entirely by the strobes and has no valid/ready handshake. The block never applies back-pressure. The host must keep each strobe level for at least one clock so that it is sampled. Read data appears on `dout`, which carries 0 whenever no read is in progress. Cell decay and refresh are not modelled.

Top module: `dram_emu`

## Requirements
- R1: After reset no row is open, `dout` is 0, and a column strobe pulse taken before any row strobe leaves `dout` at 0.
- R2: The row number is taken from `addr` at the sample where `ras_n` is first seen low after being high. Later changes on `addr` while the row stays open do not change which row is accessed.
- R3: A column access begins at the sample where `cas_n` is first seen low after being high, with the row open and `ras_n` still low. The column number is taken from `addr` at that sample.
- R4: In a read access (`we_n` high at the column sample), `dout` shows the addressed bit of the open row from the clock after the column sample until the clock on which `cas_n` is sampled high. At all other times, including during a write access, `dout` is 0.
- R5: In a write access (`we_n` low at the column sample), the `din` value at that sample replaces the addressed bit of the row register. A later read of the same column in the same open row returns the new value.
- R6: Several column accesses to different columns, reads and writes mixed, may follow one row opening without reopening the row.
- R7: The sample where `ras_n` is first seen high closes the row and copies the row register back into that row. A reopened row shows its written bits, and other rows keep their contents.
- R8: A column strobe fall seen while `ras_n` is sampled high is ignored, including when it comes in the same sample as the row strobe rise. `dout` stays 0, and a write attempted that way leaves the stored bit unchanged.
- R9: A column strobe fall in the same sample as the row strobe fall is ignored. `dout` stays 0, and `cas_n` must go high and low again to access the row.
- R10: A row strobe rise while `cas_n` is still low ends the access, and `dout` is 0 from the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Shared address bus: row number, then column number |
| ras_n | input | 1 | Active-low row strobe |
| cas_n | input | 1 | Active-low column strobe |
| we_n | input | 1 | Active-low write select, sampled with the column strobe fall |
| din | input | 1 | Write data bit |
| dout | output | 1 | Read data bit, 0 when no read is in progress |

## Verification
Closing a row and starting a column access can land on the same sample. The same is true of opening a row and starting a column access. The bench provokes both by changing `ras_n` and `cas_n` at the same falling clock edge, once with a read and once with a write. In each case it requires `dout` to stay 0. After the close-with-write collision, it reopens the row and reads the bit back, which must be unchanged. After the open-with-column collision, it toggles `cas_n` again and expects a normal read.

// File: rtl/dram_emu_pkg.sv
package dram_emu_pkg;
  // One sampled strobe event pair; fall = 1->0, rise = 0->1 between samples
  typedef struct packed {
    logic fall;
    logic rise;
  } strobe_ev_t;

  localparam int NUM_STB = 2;
  localparam int STB_ROW = 0;
  localparam int STB_COL = 1;
endpackage

// File: rtl/dram_strobe_edge.sv
module dram_strobe_edge
  import dram_emu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe_n,
  output strobe_ev_t ev
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= strobe_n;
  end

  assign ev.fall = prev_q & ~strobe_n;
  assign ev.rise = ~prev_q & strobe_n;
endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic [AW-1:0]     rd_row,
  output logic [(1<<AW)-1:0] rd_bits,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_row,
  input  logic [(1<<AW)-1:0] wr_bits
);
  localparam int ROWS = 1 << AW;
  localparam int COLS = 1 << AW;

  logic [COLS-1:0] cells [ROWS];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_row] <= wr_bits;
  end

  assign rd_bits = cells[rd_row];
endmodule

// File: rtl/dram_row_buffer.sv
module dram_row_buffer #(
  parameter int AW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [(1<<AW)-1:0] load_bits,
  input  logic               col_go,
  input  logic               col_stop,
  input  logic [AW-1:0]      col,
  input  logic               wr,
  input  logic               wdata,
  output logic [(1<<AW)-1:0] row_bits,
  output logic               rdata
);
  localparam int COLS = 1 << AW;

  logic [COLS-1:0] row_q;
  logic [AW-1:0]   col_q;
  logic            rd_act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
    end else if (load) begin
      row_q <= load_bits;
    end else if (col_go && wr) begin
      row_q[col] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_act_q <= 1'b0;
      col_q    <= '0;
    end else if (col_go) begin
      rd_act_q <= ~wr;
      col_q    <= col;
    end else if (col_stop) begin
      rd_act_q <= 1'b0;
    end
  end

  assign row_bits = row_q;
  assign rdata    = rd_act_q & row_q[col_q];
endmodule

// File: rtl/dram_emu.sv
module dram_emu
  import dram_emu_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          ras_n,
  input  logic          cas_n,
  input  logic          we_n,
  input  logic          din,
  output logic          dout
);
  localparam int COLS = 1 << AW;

  logic [NUM_STB-1:0] stb_n;
  strobe_ev_t         ev [NUM_STB];

  assign stb_n[STB_ROW] = ras_n;
  assign stb_n[STB_COL] = cas_n;

  for (genvar g = 0; g < NUM_STB; g++) begin : g_stb
    dram_strobe_edge u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_n (stb_n[g]),
      .ev       (ev[g])
    );
  end

  logic            row_open;
  logic [AW-1:0]   row_addr_q;
  logic            row_start;
  logic            row_end;
  logic            col_go;
  logic            col_stop;
  logic [COLS-1:0] arr_bits;
  logic [COLS-1:0] buf_bits;

  assign row_start = ev[STB_ROW].fall;
  assign row_end   = ev[STB_ROW].rise & row_open;
  // the row must already be open and the row strobe still low at this sample
  assign col_go    = ev[STB_COL].fall & row_open & ~ev[STB_ROW].rise;
  assign col_stop  = ev[STB_COL].rise | ev[STB_ROW].rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_open   <= 1'b0;
      row_addr_q <= '0;
    end else if (row_start) begin
      row_open   <= 1'b1;
      row_addr_q <= addr;
    end else if (ev[STB_ROW].rise) begin
      row_open   <= 1'b0;
    end
  end

  dram_cell_array #(.AW(AW)) u_array (
    .clk     (clk),
    .rd_row  (addr),
    .rd_bits (arr_bits),
    .wr_en   (row_end),
    .wr_row  (row_addr_q),
    .wr_bits (buf_bits)
  );

  dram_row_buffer #(.AW(AW)) u_rowbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (row_start),
    .load_bits (arr_bits),
    .col_go    (col_go),
    .col_stop  (col_stop),
    .col       (addr),
    .wr        (~we_n),
    .wdata     (din),
    .row_bits  (buf_bits),
    .rdata     (dout)
  );
endmodule

// File: rtl/dram_emu_chk.sv
module dram_emu_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ras_n,
  input logic          cas_n,
  input logic          dout,
  input logic          row_open,
  input logic [AW-1:0] row_addr_q
);
  AST_COL_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cas_n) |-> !dout); // R4
  AST_ROW_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ras_n) |-> !dout); // R8
  AST_ROW_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ras_n) |-> !row_open); // R7
  AST_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (row_open && $past(row_open)) |-> $stable(row_addr_q)); // R2
  AST_DOUT_NEEDS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    dout |-> row_open); // R3
endmodule

bind dram_emu dram_emu_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ras_n      (ras_n),
  .cas_n      (cas_n),
  .dout       (dout),
  .row_open   (row_open),
  .row_addr_q (row_addr_q)
);

// File: tb/tb_dram_emu.sv
module tb_dram_emu;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int MAX_CYC = 150000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          ras_n, cas_n, we_n, din;
  logic          dout;

  int  total = 0;
  int  bad = 0;
  bit  done = 0;
  int  cur_row = 0;
  logic [(1<<AW)-1:0] model [1<<AW];
  int  rows_set [6] = '{0, 1, 7, 128, 200, 255};

  dram_emu #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .din(din), .dout(dout)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_bit(input int r, input int c);
    return int'(model[r][c]);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic open_row(input int r);
    @(negedge clk);
    addr = AW'(r); ras_n = 1'b0; cur_row = r;
  endtask

  task automatic close_row();
    @(negedge clk);
    ras_n = 1'b1;
    @(negedge clk);
    chk("R7", int'(dout), 0);
  endtask

  // one column cycle; reads are compared with the model, writes update it
  task automatic access(input int c, input bit wr, input bit d, input string req);
    @(negedge clk);
    addr = AW'(c); we_n = ~wr; din = d; cas_n = 1'b0;
    @(negedge clk);
    if (wr) begin
      chk(req, int'(dout), 0);
      model[cur_row][c] = d;
    end else begin
      chk(req, int'(dout), exp_bit(cur_row, c));
    end
    addr = AW'($urandom); cas_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
    chk("R4", int'(dout), 0);
  endtask

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R3 watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit b;
    void'($urandom(32'h1b2c3d4e));
    rst_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; din = 1'b0; addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(dout), 0);
    addr = 8'd5; cas_n = 1'b0;
    @(negedge clk);
    chk("R1", int'(dout), 0);
    cas_n = 1'b1;
    @(negedge clk);

    // fill every row used later with known data
    foreach (rows_set[i]) begin
      open_row(rows_set[i]);
      for (int c = 0; c < (1 << AW); c++) access(c, 1'b1, 1'($urandom), "R5");
      close_row();
    end

    // R2: address bus wiggles while the row stays open
    open_row(128);
    @(negedge clk); addr = 8'd200;
    @(negedge clk); addr = 8'd0;
    access(10, 1'b0, 1'b0, "R2");
    access(11, 1'b0, 1'b0, "R6");
    access(250, 1'b0, 1'b0, "R6");
    close_row();

    // R5 / R6 / R7: write, read back in page, close, reopen
    open_row(1);
    b = ~model[1][33];
    access(33, 1'b1, b, "R5");
    access(33, 1'b0, 1'b0, "R5");
    access(34, 1'b0, 1'b0, "R6");
    access(35, 1'b1, ~model[1][35], "R6");
    access(35, 1'b0, 1'b0, "R6");
    close_row();
    open_row(1);
    access(33, 1'b0, 1'b0, "R7");
    access(35, 1'b0, 1'b0, "R7");
    close_row();
    open_row(0);
    access(33, 1'b0, 1'b0, "R7");
    close_row();

    // R8: column strobe with row strobe high
    open_row(200);
    access(50, 1'b1, 1'b1, "R8");
    close_row();
    @(negedge clk); addr = 8'd50; we_n = 1'b1; cas_n = 1'b0;
    @(negedge clk); chk("R8", int'(dout), 0); cas_n = 1'b1;
    @(negedge clk);
    // R8: row rise and column fall in the same sample, read
    open_row(200);
    access(50, 1'b0, 1'b0, "R8");
    @(negedge clk); ras_n = 1'b1; cas_n = 1'b0; addr = 8'd50; we_n = 1'b1;
    @(negedge clk); chk("R8", int'(dout), 0); cas_n = 1'b1;
    @(negedge clk);
    // R8: same collision with a write; stored bit must survive
    open_row(200);
    @(negedge clk); ras_n = 1'b1; cas_n = 1'b0; addr = 8'd50; we_n = 1'b0; din = 1'b0;
    @(negedge clk); cas_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
    open_row(200);
    access(50, 1'b0, 1'b0, "R8");
    close_row();

    // R9: row and column strobe fall together
    open_row(7);
    access(7, 1'b1, 1'b1, "R9");
    close_row();
    @(negedge clk); addr = 8'd7; we_n = 1'b1; ras_n = 1'b0; cas_n = 1'b0; cur_row = 7;
    @(negedge clk); chk("R9", int'(dout), 0); cas_n = 1'b1;
    @(negedge clk); chk("R9", int'(dout), 0);
    access(7, 1'b0, 1'b0, "R9");
    close_row();

    // R10: row closes while column strobe is still low
    open_row(7);
    @(negedge clk); addr = 8'd7; we_n = 1'b1; cas_n = 1'b0;
    @(negedge clk); chk("R10", int'(dout), exp_bit(7, 7)); ras_n = 1'b1;
    @(negedge clk); chk("R10", int'(dout), 0); cas_n = 1'b1;
    @(negedge clk);

    // random page-mode traffic over the initialised rows
    for (int it = 0; it < 250; it++) begin
      int n;
      open_row(rows_set[$urandom_range(0, 5)]);
      n = $urandom_range(1, 4);
      for (int k = 0; k < n; k++) begin
        if ($urandom_range(0, 2) == 0)
          access($urandom_range(0, 255), 1'b1, 1'($urandom), "R5");
        else
          access($urandom_range(0, 255), 1'b0, 1'b0, "R3");
      end
      close_row();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule